// File: doc/BRIEF.md
# Wide-Port Pipelined Matrix Multiplier

This block multiplies a DIM_N×DIM_M matrix A by a DIM_M×DIM_P matrix B of 32-bit signed integers (all three dimensions default to 32). It produces the DIM_N×DIM_P product at one result element per clock. Two operand stores hold the matrices in wide words. Each word of the A store holds one complete row of A. Each word of the B store holds one complete column of B. One read of each store therefore supplies everything that one dot product needs.

Every cycle of a run, the sequencer reads one A row and one B column. The datapath multiplies all DIM_M lane pairs at once and reduces them through a registered binary adder tree. All arithmetic wraps modulo 2^32. The host loads both stores through their write ports and pulses `start`. Results then stream out in row-major order, each tagged with its row and column. A one-cycle `done` pulse closes the run.

Top module: `mm_rowcol_mult`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done` and `res_valid` are low until a start is accepted.
- R2: A write to the A store at address i stores row i, with element A[i][k] in bits [k*32 +: 32]. A write to the B store at address j stores column j, with element B[k][j] in bits [k*32 +: 32].
- R3: A write whose 6-bit address is DIM_N or more (A store) or DIM_P or more (B store) is discarded and changes no stored word.
- R4: Each result equals the sum over k of A[i][k]*B[k][j], taken as 32-bit two's-complement values with products and sums wrapping modulo 2^32.
- R5: A run yields exactly DIM_N*DIM_P results on consecutive cycles in row-major order: column index inner, row index outer, starting at (0,0).
- R6: The first result of a run has `res_valid` high after the 7th rising edge following the edge that samples `start`. This latency is 2 + log2(DIM_M): one edge for the store read, one for the products, and one per adder-tree level.
- R7: `done` is high for exactly one cycle, in the cycle right after the last result. `busy` falls at the same edge.
- R8: A `start` pulse while `busy` is high is ignored: no extra results and no extra `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_wr_en | input | 1 | Write strobe for the A row store |
| a_wr_addr | input | 6 | Row index for the A write |
| a_wr_row | input | 1024 | Packed row of A, element k in bits [k*32 +: 32] |
| b_wr_en | input | 1 | Write strobe for the B column store |
| b_wr_addr | input | 6 | Column index for the B write |
| b_wr_col | input | 1024 | Packed column of B, element k in bits [k*32 +: 32] |
| start | input | 1 | Begin a product run when idle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| res_valid | output | 1 | Result element present |
| res_row | output | 5 | Row index of the result |
| res_col | output | 5 | Column index of the result |
| res_data | output | 32 | Result element value |

## Verification
On every cycle, the assertions check the shape of the output stream. They check that results arrive with no gaps and that the indices step in row-major order from the origin. They also check that `done` is a single pulse tied to the final element and that no result appears while the block is idle.

The numerical content can only be shown by the bench scenarios. These compare every element against a triple-loop reference for zero, identity, random and extreme-magnitude matrices. The bench scenarios also cover the start-to-first-result latency, discarded out-of-range writes, and a start pulse issued mid-run.

// File: rtl/mm_pkg.sv
package mm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } mm_state_e;

endpackage

// File: rtl/mm_opmem.sv
// Wide single-write, single-read operand store. Each word holds one packed
// operand vector (a row of A or a column of B). Read data is registered.
module mm_opmem #(
    parameter  int DEPTH  = 32,
    parameter  int ADDR_W = 6,
    parameter  int WORD_W = 1024,
    localparam int IW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [WORD_W-1:0] rd_q;
    logic              in_range;

    // Addresses at or above DEPTH are dropped rather than aliased.
    assign in_range = ({1'b0, wr_addr} < (ADDR_W+1)'(DEPTH));

    always_ff @(posedge clk) begin
        if (wr_en && in_range) begin
            mem_q[wr_addr[IW-1:0]] <= wr_data;
        end
        rd_q <= mem_q[rd_addr];
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/mm_dot.sv
// LANES-wide dot product: one registered multiply stage followed by
// log2(LANES) registered adder levels. Latency = 1 + log2(LANES) edges.
// LANES must be a power of two. All arithmetic wraps at W bits.
module mm_dot #(
    parameter int LANES = 32,
    parameter int W     = 32
) (
    input  logic               clk,
    input  logic [LANES*W-1:0] a_vec,
    input  logic [LANES*W-1:0] b_vec,
    output logic [W-1:0]       sum
);

    localparam int LVL = $clog2(LANES);

    for (genvar lv = 0; lv <= LVL; lv++) begin : g_lvl
        localparam int CNT = LANES >> lv;
        logic [W-1:0] s_d [CNT];
        logic [W-1:0] s_q [CNT];

        if (lv == 0) begin : g_mul
            always_comb begin
                for (int n = 0; n < CNT; n++) begin
                    s_d[n] = a_vec[n*W +: W] * b_vec[n*W +: W];
                end
            end
        end else begin : g_add
            always_comb begin
                for (int n = 0; n < CNT; n++) begin
                    s_d[n] = g_lvl[lv-1].s_q[2*n] + g_lvl[lv-1].s_q[2*n+1];
                end
            end
        end

        always_ff @(posedge clk) begin
            s_q <= s_d;
        end
    end

    assign sum = g_lvl[LVL].s_q[0];

endmodule

// File: rtl/mm_seq.sv
// Run sequencer: walks (i,j) in row-major order at one pair per cycle,
// carries the index tags down a LAT-deep pipe, and raises done once the
// final tag leaves the pipe.
module mm_seq
    import mm_pkg::*;
#(
    parameter  int DIM_N = 32,
    parameter  int DIM_P = 32,
    parameter  int LAT   = 7,
    localparam int RW    = $clog2(DIM_N),
    localparam int CW    = $clog2(DIM_P)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic [RW-1:0] a_rd_addr,
    output logic [CW-1:0] b_rd_addr,
    output logic          busy,
    output logic          done,
    output logic          out_valid,
    output logic [RW-1:0] out_row,
    output logic [CW-1:0] out_col
);

    typedef struct packed {
        mm_state_e         st;
        logic [RW-1:0]     i;
        logic [CW-1:0]     j;
        logic [LAT-1:0]    v;
        logic [LAT*RW-1:0] ri;
        logic [LAT*CW-1:0] ci;
        logic              done;
    } seq_state_t;

    seq_state_t q, d;
    logic       issue;
    logic       last_out;

    assign issue    = (q.st == ST_RUN);
    assign last_out = q.v[LAT-1]
                   && (q.ri[LAT*RW-1 -: RW] == RW'(DIM_N-1))
                   && (q.ci[LAT*CW-1 -: CW] == CW'(DIM_P-1));

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.v    = {q.v[LAT-2:0], issue};
        d.ri   = {q.ri[(LAT-1)*RW-1:0], q.i};
        d.ci   = {q.ci[(LAT-1)*CW-1:0], q.j};
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st = ST_RUN;
                    d.i  = '0;
                    d.j  = '0;
                end
            end
            ST_RUN: begin
                if (q.j == CW'(DIM_P-1)) begin
                    d.j = '0;
                    if (q.i == RW'(DIM_N-1)) begin
                        d.i  = '0;
                        d.st = ST_DRAIN;
                    end else begin
                        d.i = q.i + 1'b1;
                    end
                end else begin
                    d.j = q.j + 1'b1;
                end
            end
            ST_DRAIN: begin
                if (last_out) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign a_rd_addr = q.i;
    assign b_rd_addr = q.j;
    assign busy      = (q.st != ST_IDLE);
    assign done      = q.done;
    assign out_valid = q.v[LAT-1];
    assign out_row   = q.ri[LAT*RW-1 -: RW];
    assign out_col   = q.ci[LAT*CW-1 -: CW];

endmodule

// File: rtl/mm_rowcol_mult.sv
// Top: row-packed A store, column-packed B store, sequencer, dot-product tree.
module mm_rowcol_mult #(
    parameter  int DIM_N  = 32,
    parameter  int DIM_M  = 32,
    parameter  int DIM_P  = 32,
    parameter  int ELEM_W = 32,
    parameter  int ADDR_W = 6,
    localparam int VEC_W  = DIM_M * ELEM_W,
    localparam int RW     = $clog2(DIM_N),
    localparam int CW     = $clog2(DIM_P),
    localparam int LAT    = 2 + $clog2(DIM_M)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_wr_en,
    input  logic [ADDR_W-1:0] a_wr_addr,
    input  logic [VEC_W-1:0]  a_wr_row,
    input  logic              b_wr_en,
    input  logic [ADDR_W-1:0] b_wr_addr,
    input  logic [VEC_W-1:0]  b_wr_col,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              res_valid,
    output logic [RW-1:0]     res_row,
    output logic [CW-1:0]     res_col,
    output logic [ELEM_W-1:0] res_data
);

    logic [RW-1:0]    a_rd_addr;
    logic [CW-1:0]    b_rd_addr;
    logic [VEC_W-1:0] a_vec;
    logic [VEC_W-1:0] b_vec;

    mm_opmem #(
        .DEPTH (DIM_N),
        .ADDR_W(ADDR_W),
        .WORD_W(VEC_W)
    ) a_store_i (
        .clk    (clk),
        .wr_en  (a_wr_en),
        .wr_addr(a_wr_addr),
        .wr_data(a_wr_row),
        .rd_addr(a_rd_addr),
        .rd_data(a_vec)
    );

    mm_opmem #(
        .DEPTH (DIM_P),
        .ADDR_W(ADDR_W),
        .WORD_W(VEC_W)
    ) b_store_i (
        .clk    (clk),
        .wr_en  (b_wr_en),
        .wr_addr(b_wr_addr),
        .wr_data(b_wr_col),
        .rd_addr(b_rd_addr),
        .rd_data(b_vec)
    );

    mm_seq #(
        .DIM_N(DIM_N),
        .DIM_P(DIM_P),
        .LAT  (LAT)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .a_rd_addr(a_rd_addr),
        .b_rd_addr(b_rd_addr),
        .busy     (busy),
        .done     (done),
        .out_valid(res_valid),
        .out_row  (res_row),
        .out_col  (res_col)
    );

    mm_dot #(
        .LANES(DIM_M),
        .W    (ELEM_W)
    ) dot_i (
        .clk  (clk),
        .a_vec(a_vec),
        .b_vec(b_vec),
        .sum  (res_data)
    );

endmodule

// File: rtl/mm_rowcol_mult_chk.sv
module mm_rowcol_mult_chk #(
    parameter  int DIM_N = 32,
    parameter  int DIM_P = 32,
    localparam int RW    = $clog2(DIM_N),
    localparam int CW    = $clog2(DIM_P)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          res_valid,
    input logic [RW-1:0] res_row,
    input logic [CW-1:0] res_col
);

    logic last_el;
    assign last_el = res_valid && (res_row == RW'(DIM_N-1)) && (res_col == CW'(DIM_P-1));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        last_el |=> (done && !busy));

    p_done_needs_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(last_el));

    p_gapless_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !last_el) |=> res_valid);

    p_col_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_col != CW'(DIM_P-1)) |=>
            (res_row == $past(res_row) && res_col == CW'($past(res_col) + 1'b1)));

    p_row_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_col == CW'(DIM_P-1) && res_row != RW'(DIM_N-1)) |=>
            (res_col == '0 && res_row == RW'($past(res_row) + 1'b1)));

    p_origin_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid) |-> (res_row == '0 && res_col == '0));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !res_valid);

endmodule

bind mm_rowcol_mult mm_rowcol_mult_chk #(
    .DIM_N(DIM_N),
    .DIM_P(DIM_P)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .res_valid(res_valid),
    .res_row  (res_row),
    .res_col  (res_col)
);

// File: tb/mm_rowcol_mult_tb_top.sv
`timescale 1ns/1ps
module mm_rowcol_mult_tb_top;

    localparam int N  = 32;
    localparam int M  = 32;
    localparam int P  = 32;
    localparam int W  = 32;
    localparam int AW = 6;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            a_wr_en, b_wr_en, start;
    logic [AW-1:0]   a_wr_addr, b_wr_addr;
    logic [M*W-1:0]  a_wr_row, b_wr_col;
    logic            busy, done, res_valid;
    logic [4:0]      res_row, res_col;
    logic [W-1:0]    res_data;

    always #2 clk = ~clk;

    mm_rowcol_mult dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_wr_en(a_wr_en), .a_wr_addr(a_wr_addr), .a_wr_row(a_wr_row),
        .b_wr_en(b_wr_en), .b_wr_addr(b_wr_addr), .b_wr_col(b_wr_col),
        .start(start), .busy(busy), .done(done),
        .res_valid(res_valid), .res_row(res_row), .res_col(res_col),
        .res_data(res_data)
    );

    typedef struct { int r; int c; int v; } exp_t;
    exp_t  sb_q[$];
    int    am [N][M];
    int    bm [M][P];
    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R4";
    logic  want_done = 1'b0;
    logic  case_done = 1'b0;

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Monitor: pop expected items and compare; track the done pulse (R7, R8).
    always @(negedge clk) begin
        if (rst_n) begin
            if (want_done) begin
                chk(done && !busy, "R7 done after last", {done, busy}, 2'b10);
                want_done = 1'b0;
                case_done = 1'b1;
            end else if (done) begin
                chk(1'b0, "R8 unexpected done", 1, 0);
            end
            if (res_valid) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected result", res_data, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(res_row == 5'(e.r) && res_col == 5'(e.c), "R5 order",
                        {res_row, res_col}, {5'(e.r), 5'(e.c)});
                    chk(res_data == e.v, cur_req, res_data, e.v);
                    if (e.r == N-1 && e.c == P-1) want_done = 1'b1;
                end
            end
        end
    end

    task automatic fill(input int kind);
        for (int i = 0; i < N; i++) begin
            for (int k = 0; k < M; k++) begin
                case (kind)
                    0: begin am[i][k] = 0; bm[k][i] = 0; end
                    1: begin am[i][k] = (i == k) ? 1 : 0; bm[k][i] = int'($urandom); end
                    2: begin am[i][k] = int'($urandom); bm[k][i] = int'($urandom); end
                    3: begin
                        am[i][k] = 32'h7fffffff;
                        bm[k][i] = ((k + i) % 2 == 0) ? 32'h80000000 : 32'h7fffffff;
                    end
                    default: begin
                        am[i][k] = int'($urandom % 201) - 100;
                        bm[k][i] = int'($urandom % 201) - 100;
                    end
                endcase
            end
        end
    endtask

    task automatic load_all();
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            a_wr_en = 1'b1; a_wr_addr = AW'(i);
            for (int k = 0; k < M; k++) a_wr_row[k*W +: W] = am[i][k];
        end
        for (int j = 0; j < P; j++) begin
            @(negedge clk);
            a_wr_en = 1'b0;
            b_wr_en = 1'b1; b_wr_addr = AW'(j);
            for (int k = 0; k < M; k++) b_wr_col[k*W +: W] = bm[k][j];
        end
        @(negedge clk);
        a_wr_en = 1'b0; b_wr_en = 1'b0;
    endtask

    // R3: out-of-range writes with all-ones data; must not touch row/col 0 or 31.
    task automatic stray_writes();
        for (int s = 0; s < 2; s++) begin
            @(negedge clk);
            a_wr_en = 1'b1; a_wr_addr = (s == 0) ? AW'(32) : AW'(63); a_wr_row = '1;
            b_wr_en = 1'b1; b_wr_addr = (s == 0) ? AW'(32) : AW'(63); b_wr_col = '1;
        end
        @(negedge clk);
        a_wr_en = 1'b0; b_wr_en = 1'b0;
    endtask

    task automatic push_expected();
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < P; j++) begin
                exp_t e;
                int   s;
                s = 0;
                for (int k = 0; k < M; k++) s += am[i][k] * bm[k][j];
                e.r = i; e.c = j; e.v = s;
                sb_q.push_back(e);
            end
        end
    endtask

    task automatic run_case(input int kind, input string req, input logic stray, input logic restart);
        int lat;
        fill(kind);
        load_all();
        if (stray) stray_writes();
        cur_req   = req;
        case_done = 1'b0;
        push_expected();
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        lat = 0;
        while (!res_valid && lat < 40) begin
            @(posedge clk);
            #1 lat++;
        end
        chk(lat == 7, "R6 first-result latency", lat, 7);
        if (restart) begin
            repeat (100) @(negedge clk);
            start = 1'b1;             // R8: ignored while busy
            @(negedge clk);
            start = 1'b0;
        end
        while (!case_done) @(posedge clk);
        repeat (20) @(negedge clk);
        chk(sb_q.size() == 0, "R5 result count", sb_q.size(), 0);
        chk(!busy && !res_valid, "R8 idle after run", {busy, res_valid}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0;
        a_wr_en = 1'b0; b_wr_en = 1'b0;
        a_wr_addr = '0; b_wr_addr = '0;
        a_wr_row = '0; b_wr_col = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !res_valid, "R1 reset quiet", {busy, done, res_valid}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !res_valid, "R1 idle after reset", {busy, done, res_valid}, 0);

        run_case(0, "R4 zero matrices",      1'b0, 1'b0);
        run_case(1, "R2 identity packing",   1'b0, 1'b0);
        run_case(2, "R4 random",             1'b0, 1'b0);
        run_case(3, "R4 wrap extremes",      1'b0, 1'b0);
        run_case(4, "R3 stray writes",       1'b1, 1'b0);
        run_case(2, "R8 start while busy",   1'b0, 1'b1);

        summary();
        $finish;
    end

endmodule